// File: doc/BRIEF.md
# Scalar Integer Lane ALU

This block is the integer execution unit for one 32-bit lane of a processor datapath. It is purely combinational. A 6-bit operation code picks one operation, which is applied to two operands, A and B. The block returns a 32-bit result in the same cycle. Operand B may be a register value or a sign-extended immediate; the caller makes that choice before the operand reaches the block.

The operations are:
- bitwise logic;
- modular add and subtract;
- the low half of a product, and the high half of a signed or an unsigned product;
- shifts;
- leading-zero and trailing-zero counts;
- signed and unsigned comparisons that return a 0/1 flag;
- a register copy;
- sign extension of a byte or a half-word.

Any operation code outside the supported set gives a zero result and raises an illegal-operation flag. The decoder uses that flag to trap the instruction.

There is no state. The decoder sorts each code into a functional group. Each group has its own unit, and one output multiplexer picks the result of the selected unit.

Top module: `int_lane_alu`

## Requirements
- R1: Code 1 returns A OR B, code 2 returns A AND B, and code 3 returns A XOR B.
- R2: Code 4 returns A+B and code 5 returns A-B, both modulo 2^32.
- R3: Code 6 returns the low 32 bits of A*B. Code 7 returns bits 63:32 of the signed product, and code 8 returns bits 63:32 of the unsigned product.
- R4: Code 9 shifts A right arithmetically, code 10 shifts A right logically, and code 11 shifts A left. The shift amount is B[4:0]; bits 31:5 of B are ignored.
- R5: Code 12 returns the number of leading zero bits of A, and code 13 returns the number of trailing zero bits of A. Both return 32 when A is zero.
- R6: Codes 14 to 19 compare A and B as signed values: 14 equal, 15 not equal, 16 greater, 17 greater-or-equal, 18 less, 19 less-or-equal. The result is 1 when the relation holds and 0 otherwise.
- R7: Codes 20 to 23 compare A and B as unsigned values: 20 greater, 21 greater-or-equal, 22 less, 23 less-or-equal. The result is 1 or 0, as for R6.
- R8: Code 32 returns A unchanged. Code 43 returns A[7:0] sign-extended to 32 bits, and code 44 returns A[15:0] sign-extended to 32 bits.
- R9: Every other code returns a result of 0 with `illegal_op` set to 1. Every supported code drives `illegal_op` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Operation code |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B (register or pre-extended immediate) |
| result | output | 32 | Operation result |
| illegal_op | output | 1 | High for an unsupported operation code |

## Verification
The cases that are hardest to reach are the ones where a wrong implementation still gives plausible values.
- The high product halves only differ between signed and unsigned when an operand is negative. The stimulus therefore multiplies all-ones by all-ones, and the most negative value by two, under both codes.
- A shift amount is only truncated to B[4:0] when B[5] or a higher bit is set. Vectors with B equal to 0x24, 0x21 and 0x20 make a shifter that uses the full B produce a different result.
- The compare vectors straddle the sign boundary (1 against 0xFFFFFFFF) under both the signed and the unsigned codes, so a swapped signedness shows up.
- The zero counts are driven with a zero operand and with single-bit operands at both ends of the word.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
    localparam int XLEN = 32;
    localparam int OPW  = 6;
    localparam int SHW  = $clog2(XLEN);
    localparam int CNTW = SHW + 1;

    localparam logic [OPW-1:0] OP_OR    = 6'd1;
    localparam logic [OPW-1:0] OP_AND   = 6'd2;
    localparam logic [OPW-1:0] OP_XOR   = 6'd3;
    localparam logic [OPW-1:0] OP_ADD   = 6'd4;
    localparam logic [OPW-1:0] OP_SUB   = 6'd5;
    localparam logic [OPW-1:0] OP_MULLO = 6'd6;
    localparam logic [OPW-1:0] OP_MULHS = 6'd7;
    localparam logic [OPW-1:0] OP_MULHU = 6'd8;
    localparam logic [OPW-1:0] OP_SRA   = 6'd9;
    localparam logic [OPW-1:0] OP_SRL   = 6'd10;
    localparam logic [OPW-1:0] OP_SLL   = 6'd11;
    localparam logic [OPW-1:0] OP_LZC   = 6'd12;
    localparam logic [OPW-1:0] OP_TZC   = 6'd13;
    localparam logic [OPW-1:0] OP_SEQ   = 6'd14;
    localparam logic [OPW-1:0] OP_SNE   = 6'd15;
    localparam logic [OPW-1:0] OP_SGT   = 6'd16;
    localparam logic [OPW-1:0] OP_SGE   = 6'd17;
    localparam logic [OPW-1:0] OP_SLT   = 6'd18;
    localparam logic [OPW-1:0] OP_SLE   = 6'd19;
    localparam logic [OPW-1:0] OP_UGT   = 6'd20;
    localparam logic [OPW-1:0] OP_UGE   = 6'd21;
    localparam logic [OPW-1:0] OP_ULT   = 6'd22;
    localparam logic [OPW-1:0] OP_ULE   = 6'd23;
    localparam logic [OPW-1:0] OP_COPY  = 6'd32;
    localparam logic [OPW-1:0] OP_SXB   = 6'd43;
    localparam logic [OPW-1:0] OP_SXH   = 6'd44;

    typedef enum logic [2:0] {
        GRP_NONE  = 3'd0,
        GRP_BASIC = 3'd1,
        GRP_MUL   = 3'd2,
        GRP_SHIFT = 3'd3,
        GRP_COUNT = 3'd4,
        GRP_CMP   = 3'd5
    } unit_grp_e;
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import int_alu_pkg::*;
(
    input  logic [OPW-1:0] op_code,
    output unit_grp_e      grp_sel,
    output logic           illegal
);
    always_comb begin
        grp_sel = GRP_NONE;
        unique case (op_code)
            OP_OR, OP_AND, OP_XOR, OP_ADD, OP_SUB,
            OP_COPY, OP_SXB, OP_SXH:              grp_sel = GRP_BASIC;
            OP_MULLO, OP_MULHS, OP_MULHU:         grp_sel = GRP_MUL;
            OP_SRA, OP_SRL, OP_SLL:               grp_sel = GRP_SHIFT;
            OP_LZC, OP_TZC:                       grp_sel = GRP_COUNT;
            OP_SEQ, OP_SNE, OP_SGT, OP_SGE, OP_SLT, OP_SLE,
            OP_UGT, OP_UGE, OP_ULT, OP_ULE:       grp_sel = GRP_CMP;
            default:                              grp_sel = GRP_NONE;
        endcase
    end
    assign illegal = (grp_sel == GRP_NONE);
endmodule

// File: rtl/alu_basic_unit.sv
module alu_basic_unit
    import int_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [OPW-1:0] op_code,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    always_comb begin
        y = '0;
        unique case (op_code)
            OP_OR:   y = a | b;
            OP_AND:  y = a & b;
            OP_XOR:  y = a ^ b;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_COPY: y = a;
            OP_SXB:  y = {{(W-BYTE_W){a[BYTE_W-1]}}, a[BYTE_W-1:0]};
            OP_SXH:  y = {{(W-HALF_W){a[HALF_W-1]}}, a[HALF_W-1:0]};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_mul_unit.sv
module alu_mul_unit
    import int_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [OPW-1:0] op_code,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod_s;
    logic [PW-1:0] prod_u;

    assign prod_s = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
    assign prod_u = {{W{1'b0}}, a} * {{W{1'b0}}, b};

    always_comb begin
        y = '0;
        unique case (op_code)
            OP_MULLO: y = prod_u[W-1:0];
            OP_MULHS: y = prod_s[PW-1:W];
            OP_MULHU: y = prod_u[PW-1:W];
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/alu_shift_count_unit.sv
module alu_shift_count_unit
    import int_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [OPW-1:0]         op_code,
    input  logic [W-1:0]           a,
    input  logic [$clog2(W)-1:0]   sh_amt,
    output logic [W-1:0]           y_shift,
    output logic [W-1:0]           y_count
);
    localparam int CW = $clog2(W) + 1;

    logic [CW-1:0] lead_z;
    logic [CW-1:0] trail_z;

    always_comb begin
        lead_z = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (a[i]) lead_z = CW'(W - 1 - i);
        end
    end

    always_comb begin
        trail_z = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (a[i]) trail_z = CW'(i);
        end
    end

    always_comb begin
        y_shift = '0;
        unique case (op_code)
            OP_SRA:  y_shift = W'($signed(a) >>> sh_amt);
            OP_SRL:  y_shift = a >> sh_amt;
            OP_SLL:  y_shift = a << sh_amt;
            default: y_shift = '0;
        endcase
    end

    always_comb begin
        y_count = '0;
        unique case (op_code)
            OP_LZC:  y_count = W'(lead_z);
            OP_TZC:  y_count = W'(trail_z);
            default: y_count = '0;
        endcase
    end
endmodule

// File: rtl/alu_cmp_unit.sv
module alu_cmp_unit
    import int_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [OPW-1:0] op_code,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    logic eq, s_lt, u_lt, hit;

    assign eq   = (a == b);
    assign s_lt = ($signed(a) < $signed(b));
    assign u_lt = (a < b);

    always_comb begin
        hit = 1'b0;
        unique case (op_code)
            OP_SEQ:  hit = eq;
            OP_SNE:  hit = !eq;
            OP_SGT:  hit = !s_lt && !eq;
            OP_SGE:  hit = !s_lt;
            OP_SLT:  hit = s_lt;
            OP_SLE:  hit = s_lt || eq;
            OP_UGT:  hit = !u_lt && !eq;
            OP_UGE:  hit = !u_lt;
            OP_ULT:  hit = u_lt;
            OP_ULE:  hit = u_lt || eq;
            default: hit = 1'b0;
        endcase
    end
    assign y = {{(W-1){1'b0}}, hit};
endmodule

// File: rtl/int_lane_alu.sv
module int_lane_alu
    import int_alu_pkg::*;
(
    input  logic [OPW-1:0]  op_code,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic [XLEN-1:0] result,
    output logic            illegal_op
);
    unit_grp_e       grp_sel;
    logic [XLEN-1:0] y_basic, y_mul, y_shift, y_count, y_cmp;

    alu_op_decode u_dec (
        .op_code (op_code),
        .grp_sel (grp_sel),
        .illegal (illegal_op)
    );

    alu_basic_unit #(.W(XLEN)) u_basic (
        .op_code (op_code), .a(opnd_a), .b(opnd_b), .y(y_basic)
    );

    alu_mul_unit #(.W(XLEN)) u_mul (
        .op_code (op_code), .a(opnd_a), .b(opnd_b), .y(y_mul)
    );

    alu_shift_count_unit #(.W(XLEN)) u_shc (
        .op_code (op_code),
        .a       (opnd_a),
        .sh_amt  (opnd_b[SHW-1:0]),
        .y_shift (y_shift),
        .y_count (y_count)
    );

    alu_cmp_unit #(.W(XLEN)) u_cmp (
        .op_code (op_code), .a(opnd_a), .b(opnd_b), .y(y_cmp)
    );

    always_comb begin
        result = '0;
        unique case (grp_sel)
            GRP_BASIC: result = y_basic;
            GRP_MUL:   result = y_mul;
            GRP_SHIFT: result = y_shift;
            GRP_COUNT: result = y_count;
            GRP_CMP:   result = y_cmp;
            default:   result = '0;
        endcase
    end
endmodule

// File: rtl/int_lane_alu_chk.sv
module int_lane_alu_chk
    import int_alu_pkg::*;
(
    input logic [OPW-1:0]  op_code,
    input logic [XLEN-1:0] opnd_a,
    input logic [XLEN-1:0] opnd_b,
    input logic [XLEN-1:0] result,
    input logic            illegal_op
);
    logic known;
    assign known = !$isunknown({op_code, opnd_a, opnd_b});

    always_comb begin
        if (known) begin
            // R9: a flagged code never leaks a value
            a_r9_illegal_zero: assert (!illegal_op || result == '0)
                else $error("illegal op produced nonzero result");
            // R6 / R7: compares produce only 0 or 1
            if (op_code >= OP_SEQ && op_code <= OP_ULE)
                a_r6_r7_bool_result: assert (result[XLEN-1:1] == '0)
                    else $error("compare result not boolean");
            // R5: zero counts stay within 0..32
            if (op_code == OP_LZC || op_code == OP_TZC)
                a_r5_count_range: assert (result <= XLEN)
                    else $error("zero count out of range");
            // R8: byte sign extension fills upper bits with one value
            if (op_code == OP_SXB)
                a_r8_sext_fill: assert (result[XLEN-1:7] == '0 || result[XLEN-1:7] == '1)
                    else $error("byte extension upper bits mixed");
            // R4: left shift clears the vacated low bits
            if (op_code == OP_SLL)
                a_r4_shl_low_clear: assert ((result & ((XLEN'(1) << opnd_b[SHW-1:0]) - XLEN'(1))) == '0)
                    else $error("left shift left low bits set");
        end
    end
endmodule

bind int_lane_alu int_lane_alu_chk u_chk (
    .op_code    (op_code),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .result     (result),
    .illegal_op (illegal_op)
);

// File: tb/sim_int_lane_alu.sv
`timescale 1ns/1ps
module sim_int_lane_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  op_code;
    logic [31:0] opnd_a, opnd_b;
    logic [31:0] result;
    logic        illegal_op;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    int_lane_alu u0 (
        .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .illegal_op(illegal_op)
    );

    typedef struct packed {
        logic [5:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        logic        ill;
    } vec_t;

    localparam int NV = 43;
    localparam vec_t VECS [NV] = '{
        '{6'd1,  32'h1234_0000, 32'h0000_5678, 32'h1234_5678, 1'b0}, // R1 or
        '{6'd2,  32'hFF00_FF00, 32'h0F0F_0F0F, 32'h0F00_0F00, 1'b0}, // R1 and
        '{6'd3,  32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0F0F, 1'b0}, // R1 xor
        '{6'd4,  32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0001, 1'b0}, // R2 add wrap
        '{6'd5,  32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0}, // R2 sub wrap
        '{6'd6,  32'hFFFF_FFFD, 32'h0000_0007, 32'hFFFF_FFEB, 1'b0}, // R3 low
        '{6'd7,  32'h8000_0000, 32'h0000_0002, 32'hFFFF_FFFF, 1'b0}, // R3 high signed
        '{6'd8,  32'h8000_0000, 32'h0000_0002, 32'h0000_0001, 1'b0}, // R3 high unsigned
        '{6'd7,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0}, // R3
        '{6'd8,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0}, // R3
        '{6'd9,  32'h8000_0000, 32'h0000_0004, 32'hF800_0000, 1'b0}, // R4 sra
        '{6'd9,  32'h8000_0000, 32'h0000_0024, 32'hF800_0000, 1'b0}, // R4 amount masked
        '{6'd10, 32'h8000_0000, 32'h0000_0004, 32'h0800_0000, 1'b0}, // R4 srl
        '{6'd10, 32'h8000_0000, 32'h0000_0021, 32'h4000_0000, 1'b0}, // R4 masked
        '{6'd11, 32'h0000_0001, 32'h0000_001F, 32'h8000_0000, 1'b0}, // R4 sll
        '{6'd11, 32'h0000_0001, 32'h0000_0020, 32'h0000_0001, 1'b0}, // R4 masked
        '{6'd12, 32'h0001_0000, 32'h0000_0000, 32'd15,        1'b0}, // R5 lzc
        '{6'd12, 32'h0000_0000, 32'h0000_0000, 32'd32,        1'b0}, // R5 zero
        '{6'd12, 32'h8000_0000, 32'h0000_0000, 32'd0,         1'b0}, // R5
        '{6'd13, 32'h0001_0000, 32'h0000_0000, 32'd16,        1'b0}, // R5 tzc
        '{6'd13, 32'h0000_0000, 32'h0000_0000, 32'd32,        1'b0}, // R5 zero
        '{6'd13, 32'h0000_0001, 32'h0000_0000, 32'd0,         1'b0}, // R5
        '{6'd14, 32'd5,         32'd5,         32'd1,         1'b0}, // R6 eq
        '{6'd14, 32'd5,         32'd6,         32'd0,         1'b0}, // R6
        '{6'd15, 32'd5,         32'd6,         32'd1,         1'b0}, // R6 ne
        '{6'd16, 32'd1,         32'hFFFF_FFFF, 32'd1,         1'b0}, // R6 gt
        '{6'd17, 32'd5,         32'd5,         32'd1,         1'b0}, // R6 ge
        '{6'd18, 32'hFFFF_FFFF, 32'd1,         32'd1,         1'b0}, // R6 lt
        '{6'd19, 32'd1,         32'hFFFF_FFFF, 32'd0,         1'b0}, // R6 le
        '{6'd20, 32'hFFFF_FFFF, 32'd1,         32'd1,         1'b0}, // R7 gt
        '{6'd21, 32'd1,         32'hFFFF_FFFF, 32'd0,         1'b0}, // R7 ge
        '{6'd22, 32'd1,         32'hFFFF_FFFF, 32'd1,         1'b0}, // R7 lt
        '{6'd23, 32'd7,         32'd7,         32'd1,         1'b0}, // R7 le
        '{6'd16, 32'd7,         32'd7,         32'd0,         1'b0}, // R6 gt equal
        '{6'd32, 32'hDEAD_BEEF, 32'd1,         32'hDEAD_BEEF, 1'b0}, // R8 copy
        '{6'd43, 32'h1234_5680, 32'd0,         32'hFFFF_FF80, 1'b0}, // R8 sext8
        '{6'd43, 32'h0000_017F, 32'd0,         32'h0000_007F, 1'b0}, // R8
        '{6'd44, 32'h0001_8000, 32'd0,         32'hFFFF_8000, 1'b0}, // R8 sext16
        '{6'd24, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0,         1'b1}, // R9
        '{6'd33, 32'hFFFF_FFFF, 32'd3,         32'd0,         1'b1}, // R9
        '{6'd45, 32'h0000_0080, 32'd0,         32'd0,         1'b1}, // R9
        '{6'd63, 32'h1234_5678, 32'd1,         32'd0,         1'b1}, // R9
        '{6'd31, 32'h1234_5678, 32'd1,         32'd0,         1'b1}  // R9
    };

    task automatic check(input string req, input logic [31:0] exp_y, input logic exp_ill);
        n_chk++;
        if (result !== exp_y || illegal_op !== exp_ill) begin
            n_fail++;
            $display("FAIL %s op=%0d: result=%h illegal=%b expected result=%h illegal=%b",
                     req, op_code, result, illegal_op, exp_y, exp_ill);
        end
    endtask

    task automatic apply(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        op_code = op; opnd_a = a; opnd_b = b;
        @(negedge clk);
    endtask

    initial begin
        op_code = '0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Initial state: code 0 is unsupported (R9)
        @(negedge clk);
        check("R9 reset-state", 32'd0, 1'b1);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].a, VECS[i].b);
            check($sformatf("vector %0d", i), VECS[i].exp, VECS[i].ill);
        end

        // R9: a supported code after an illegal one clears the flag
        apply(6'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check("R9 code0", 32'd0, 1'b1);
        apply(6'd4, 32'd10, 32'd20);
        check("R2 after illegal", 32'd30, 1'b0);
        // R4: high bits of B ignored across a full shift
        apply(6'd10, 32'hF000_000F, 32'hFFFF_FFE0);
        check("R4 b-high-ignored", 32'hF000_000F, 1'b0);
        // R5: top and bottom bits set together
        apply(6'd12, 32'h8000_0001, 32'd0);
        check("R5 lzc both-ends", 32'd0, 1'b0);
        apply(6'd13, 32'h8000_0000, 32'd0);
        check("R5 tzc msb", 32'd31, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule